// File: doc/BRIEF.md
# Shape-Adaptive Vector Packing Controller

This block is the addressing and control front end of an 8x8 transform that works on arbitrarily shaped objects. In the first pass it takes a block column by column from a pixel stream. Each pixel carries a one-bit object mask. The block packs only the in-object pixels of a column, in arrival order, into a vector register and records the column's length. Packing happens as the pixels arrive. A running count picks the slot for each kept pixel, so no shift cycles are spent. Two vector buffers, each with its own count, take turns. One is being filled while the other is offered to the transform datapath over a valid/ready handshake. Their roles swap as soon as the offered vector has been taken.

When all eight columns are done and the last column vector has been taken, the second pass starts. It reads intermediate results back from a transpose memory. The row vectors are built from the recorded column lengths: row r collects the entry of every column longer than r, in column order. A block entirely outside the object produces nothing. A block entirely inside produces sixteen full-length vectors, the same as a plain 8x8 transform.

Top module: `saVecPack`

## Requirements
- R1: During the column pass a block is 8 columns of 8 accepted pixels, row 0 first. Every accepted pixel with pixAlpha=1 is packed, in arrival order, into lane k = number of earlier in-object pixels of its column. Lane k sits at vecData[k*DATA_W +: DATA_W]. vecLen equals the number of in-object pixels and vecIsRow is 0.
- R2: Every lane at an index of vecLen or above reads as zero while vecValid is high.
- R3: A column or row with no kept entries produces no vector. While vecValid is high, vecLen is between 1 and 8.
- R4: A vector is held with vecData, vecLen and vecIsRow unchanged while vecValid=1 and vecReady=0. Each expected vector is offered and taken exactly once, in order.
- R5: A completed column waiting for the output does not block the next column. Once the held vector's buffer is swapped out, the next column's 8 pixels are accepted within 10 cycles while the first vector is still held.
- R6: Once all 8 columns are done and the last column vector is taken, rows 0..7 follow. Row r holds, in increasing column order, the transpose data at address r*8+c for every column c whose recorded length exceeds r. tmData is returned the cycle after tmRdEn. Its length is the count of such columns and vecIsRow is 1.
- R7: tmRdEn is raised only for addresses r*8+c with column c's length greater than r, once each. Rows of zero length end the row pass.
- R8: A block with every mask bit 0 produces no vector and no transpose read, and the next block is then accepted.
- R9: A block with every mask bit 1 produces 8 column vectors and 8 row vectors, all of length 8.
- R10: pixReady is low throughout the row pass, so no pixel of the next block is taken during it.
- R11: Under reset vecValid and tmRdEn are 0. Right after reset pixReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| pixValid | input | 1 | pixel present on pixData |
| pixReady | output | 1 | pixel taken at the next edge when pixValid is high |
| pixData | input | DATA_W | pixel value |
| pixAlpha | input | 1 | 1 when the pixel lies inside the object |
| tmRdEn | output | 1 | transpose memory read strobe |
| tmAddr | output | 2*log2(BLK_N) | transpose read address, row*8+column |
| tmData | input | DATA_W | transpose read data, one cycle after tmRdEn |
| vecValid | output | 1 | packed vector offered |
| vecReady | input | 1 | transform datapath takes the vector |
| vecData | output | BLK_N*DATA_W | packed vector, lane 0 in the low bits |
| vecLen | output | log2(BLK_N+1) | vector length 1..8 |
| vecIsRow | output | 1 | 0 for a column vector, 1 for a row vector |

## Verification
The bench aims at empty columns in the middle of a block, columns whose only kept pixel is on the last row, and all-out and all-in blocks. A design that mishandles these would emit a zero-length vector, drop a row entry, or stall forever in the row pass. It holds vecReady low across a column boundary. A buffer swap at the wrong moment would then overwrite the held vector or stall the input behind it. It also checks that lanes past the length read zero, so stale data left from a longer earlier vector shows up as a mismatch. Row vectors are compared against a transpose-memory model that flags reads of columns that are too short. An off-by-one in the length comparison therefore shows up both as a wrong vector and as a bad read.

// File: rtl/saPackPkg.sv
package saPackPkg;

  typedef enum logic [2:0] {
    PS_VFILL,
    PS_VDRAIN,
    PS_HSCAN,
    PS_HFLUSH,
    PS_HHAND
  } packState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrEn;      // write one entry at the filling count
    logic wrFromTm;  // entry comes from transpose memory
    logic swap;      // exchange filling and offered buffers
    logic swapRow;   // the swapped-in vector is a row vector
  } packStrobe_t;

endpackage

// File: rtl/saPackDp.sv
module saPackDp
  import saPackPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BLK_N = 8,
  localparam int IDX_W = $clog2(BLK_N),
  localparam int CNT_W = $clog2(BLK_N + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  packStrobe_t             st,
  input  logic [DATA_W-1:0]       pixData,
  input  logic [DATA_W-1:0]       tmData,
  input  logic                    vecReady,
  output logic [CNT_W-1:0]        fillCnt,
  output logic                    curValid,
  output logic [BLK_N*DATA_W-1:0] vecData,
  output logic [CNT_W-1:0]        vecLen,
  output logic                    vecIsRow
);

  logic [DATA_W-1:0] bufMem [2][BLK_N];
  logic [CNT_W-1:0]  cnt [2];
  logic              sel;
  logic              curSel;
  logic              curRow;
  logic [DATA_W-1:0] wrData;

  assign curSel  = ~sel;
  assign wrData  = st.wrFromTm ? tmData : pixData;
  assign fillCnt = cnt[sel];
  assign vecLen  = cnt[curSel];
  assign vecIsRow = curRow;

  always_ff @(posedge clk) begin
    if (st.wrEn) bufMem[sel][cnt[sel][IDX_W-1:0]] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel      <= 1'b0;
      cnt[0]   <= '0;
      cnt[1]   <= '0;
      curValid <= 1'b0;
      curRow   <= 1'b0;
    end else begin
      if (st.wrEn) cnt[sel] <= cnt[sel] + 1'b1;
      if (st.swap) begin
        sel         <= curSel;
        cnt[curSel] <= '0;
        curValid    <= 1'b1;
        curRow      <= st.swapRow;
      end else if (curValid && vecReady) begin
        curValid <= 1'b0;
      end
    end
  end

  for (genvar k = 0; k < BLK_N; k++) begin : g_lane
    assign vecData[k*DATA_W +: DATA_W] =
      (CNT_W'(k) < vecLen) ? bufMem[curSel][k] : '0;
  end

  AST_WR_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    st.wrEn |-> cnt[sel] != CNT_W'(BLK_N)); // R1
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    curValid |-> (vecLen != '0 && vecLen <= CNT_W'(BLK_N))); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (curValid && !vecReady) |=> (curValid && $stable(vecData) && $stable(vecLen) && $stable(vecIsRow))); // R4
  AST_NO_WR_SWAP: assert property (@(posedge clk) disable iff (!rstN)
    st.swap |-> !st.wrEn); // R5

endmodule

// File: rtl/saPackCtrl.sv
module saPackCtrl
  import saPackPkg::*;
#(
  parameter int BLK_N = 8,
  localparam int IDX_W = $clog2(BLK_N),
  localparam int CNT_W = $clog2(BLK_N + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pixValid,
  input  logic               pixAlpha,
  input  logic [CNT_W-1:0]   fillCnt,
  input  logic               curValid,
  input  logic               vecReady,
  output logic               pixReady,
  output logic               tmRdEn,
  output logic [2*IDX_W-1:0] tmAddr,
  output packStrobe_t        st
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_N - 1);

  packState_e       state;
  logic [IDX_W-1:0] innerIdx;   // row in column pass, column in row pass
  logic [IDX_W-1:0] outerIdx;   // column in column pass, row in row pass
  logic             pendFull;
  logic             rdPend;
  logic [CNT_W-1:0] colLen [BLK_N];

  logic             accept, takeObj, colHit, firstLive, nextLive;
  logic [CNT_W-1:0] newCnt;

  assign pixReady = (state == PS_VFILL) && !pendFull;
  assign accept   = pixValid && pixReady;
  assign takeObj  = accept && pixAlpha;
  assign newCnt   = fillCnt + CNT_W'(takeObj);
  assign colHit   = int'(colLen[innerIdx]) > int'(outerIdx);
  assign tmRdEn   = (state == PS_HSCAN) && colHit;
  assign tmAddr   = {outerIdx, innerIdx};

  assign st.wrEn     = takeObj || rdPend;
  assign st.wrFromTm = rdPend;
  assign st.swap     = pendFull && (!curValid || vecReady);
  assign st.swapRow  = (state == PS_HHAND);

  always_comb begin
    firstLive = 1'b0;
    nextLive  = 1'b0;
    for (int c = 0; c < BLK_N; c++) begin
      if (colLen[c] != '0) firstLive = 1'b1;
      if (int'(colLen[c]) > int'(outerIdx) + 1) nextLive = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= PS_VFILL;
      innerIdx <= '0;
      outerIdx <= '0;
      pendFull <= 1'b0;
      rdPend   <= 1'b0;
      for (int c = 0; c < BLK_N; c++) colLen[c] <= '0;
    end else begin
      rdPend <= tmRdEn;
      if (st.swap) pendFull <= 1'b0;
      unique case (state)
        PS_VFILL: if (accept) begin
          if (innerIdx == LAST) begin
            innerIdx         <= '0;
            colLen[outerIdx] <= newCnt;
            if (newCnt != '0) pendFull <= 1'b1;
            if (outerIdx == LAST) begin
              outerIdx <= '0;
              state    <= PS_VDRAIN;
            end else begin
              outerIdx <= outerIdx + 1'b1;
            end
          end else begin
            innerIdx <= innerIdx + 1'b1;
          end
        end
        PS_VDRAIN: if (!pendFull && !curValid)
          state <= firstLive ? PS_HSCAN : PS_VFILL;
        PS_HSCAN: if (innerIdx == LAST) begin
          innerIdx <= '0;
          state    <= PS_HFLUSH;
        end else begin
          innerIdx <= innerIdx + 1'b1;
        end
        PS_HFLUSH: begin
          pendFull <= 1'b1;
          state    <= PS_HHAND;
        end
        PS_HHAND: if (st.swap) begin
          if (outerIdx == LAST || !nextLive) begin
            outerIdx <= '0;
            state    <= PS_VFILL;
          end else begin
            outerIdx <= outerIdx + 1'b1;
            state    <= PS_HSCAN;
          end
        end
        default: state <= PS_VFILL;
      endcase
    end
  end

  AST_RD_ROOM: assert property (@(posedge clk) disable iff (!rstN)
    tmRdEn |-> fillCnt < CNT_W'(BLK_N)); // R7
  AST_ROWS_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    (state == PS_HSCAN && $past(state) == PS_VDRAIN) |-> !curValid); // R6

endmodule

// File: rtl/saVecPack.sv
module saVecPack
  import saPackPkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BLK_N = 8,
  localparam int IDX_W = $clog2(BLK_N),
  localparam int CNT_W = $clog2(BLK_N + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pixValid,
  output logic                    pixReady,
  input  logic [DATA_W-1:0]       pixData,
  input  logic                    pixAlpha,
  output logic                    tmRdEn,
  output logic [2*IDX_W-1:0]      tmAddr,
  input  logic [DATA_W-1:0]       tmData,
  output logic                    vecValid,
  input  logic                    vecReady,
  output logic [BLK_N*DATA_W-1:0] vecData,
  output logic [CNT_W-1:0]        vecLen,
  output logic                    vecIsRow
);

  packStrobe_t      st;
  logic [CNT_W-1:0] fillCnt;

  saPackCtrl #(.BLK_N(BLK_N)) u_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixAlpha(pixAlpha),
    .fillCnt(fillCnt), .curValid(vecValid), .vecReady(vecReady),
    .pixReady(pixReady), .tmRdEn(tmRdEn), .tmAddr(tmAddr), .st(st)
  );

  saPackDp #(.DATA_W(DATA_W), .BLK_N(BLK_N)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .pixData(pixData), .tmData(tmData),
    .vecReady(vecReady), .fillCnt(fillCnt), .curValid(vecValid),
    .vecData(vecData), .vecLen(vecLen), .vecIsRow(vecIsRow)
  );

endmodule

// File: tb/saVecPack_test.sv
`timescale 1ns/1ps
module saVecPack_test;
  localparam int DW = 12;
  localparam int NB = 8;

  logic clk = 0, rstN = 0;
  logic pixValid = 0, pixAlpha = 0, vecReady = 0;
  logic [DW-1:0] pixData = '0, tmData = '0;
  logic pixReady, tmRdEn, vecValid, vecIsRow;
  logic [5:0] tmAddr;
  logic [NB*DW-1:0] vecData;
  logic [3:0] vecLen;

  saVecPack #(.DATA_W(DW), .BLK_N(NB)) uut (.*);

  always #2.5 clk = ~clk;

  int nChk = 0, nBad = 0, cyc = 0, blkNo = 0;
  int expCnt = 0, expIdx = 0, expReads = 0, readCnt = 0, badRead = 0, violR10 = 0;
  int readyMode = 0;  // 0 random, 1 hold low, 2 always high
  bit gapMode = 0;
  logic [63:0] alpha;
  int lens [8];
  logic [NB*DW-1:0] expVec [32];
  int expLen [32];
  bit expRow [32];

  function automatic logic [DW-1:0] pixVal(int b, int c, int r);
    return DW'(((b*61 + c*13 + r*7 + 3) % 4093) + 1);
  endfunction
  function automatic logic [DW-1:0] memVal(int b, int a);
    return DW'(((b*97 + a*29 + 5) % 4093) + 1);
  endfunction

  task automatic check(input bit ok, input string what);
    nChk++;
    if (!ok) begin nBad++; $display("FAIL %s", what); end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (tmRdEn) begin
      tmData <= memVal(blkNo, int'(tmAddr));
      readCnt++;
      if (lens[int'(tmAddr[2:0])] <= int'(tmAddr[5:3])) badRead++;
    end
  end

  logic prevHold = 0;
  logic [NB*DW-1:0] prevData;
  logic [3:0] prevLen;
  always @(negedge clk) begin
    if (prevHold)
      check(vecValid && vecData == prevData && vecLen == prevLen,
            $sformatf("R4 hold: valid=%0b len=%0d data=%h exp len=%0d data=%h",
                      vecValid, vecLen, vecData, prevLen, prevData));
    case (readyMode)
      1: vecReady = 0;
      2: vecReady = 1;
      default: vecReady = ($urandom % 10) < 7;
    endcase
    if (tmRdEn && pixReady) violR10++;
    if (rstN && vecValid && vecReady) begin
      if (expIdx >= expCnt) begin
        check(0, $sformatf("R4 extra vector len=%0d expected none", vecLen));
      end else begin
        bit okLo = 1, okHi = 1;
        for (int k = 0; k < NB; k++) begin
          if (k < expLen[expIdx]) begin
            if (vecData[k*DW +: DW] != expVec[expIdx][k*DW +: DW]) okLo = 0;
          end else if (vecData[k*DW +: DW] != '0) okHi = 0;
        end
        check(int'(vecLen) == expLen[expIdx],
              $sformatf("%s len #%0d: got %0d exp %0d", expRow[expIdx] ? "R6" : "R1",
                        expIdx, vecLen, expLen[expIdx]));
        check(okLo, $sformatf("%s data #%0d: got %h exp %h", expRow[expIdx] ? "R6" : "R1",
                              expIdx, vecData, expVec[expIdx]));
        check(okHi, $sformatf("R2 upper lanes #%0d: got %h exp %h", expIdx, vecData, expVec[expIdx]));
        check(vecIsRow == expRow[expIdx],
              $sformatf("R6 row flag #%0d: got %0b exp %0b", expIdx, vecIsRow, expRow[expIdx]));
        expIdx++;
      end
    end
    prevHold = rstN && vecValid && !vecReady;
    prevData = vecData;
    prevLen  = vecLen;
  end

  task automatic setupBlock(input logic [63:0] am);
    logic [NB*DW-1:0] v;
    int n;
    blkNo++;
    alpha = am;
    expCnt = 0; expIdx = 0; expReads = 0; readCnt = 0; badRead = 0; violR10 = 0;
    for (int c = 0; c < 8; c++) begin
      v = '0; n = 0;
      for (int r = 0; r < 8; r++)
        if (am[c*8+r]) begin v[n*DW +: DW] = pixVal(blkNo, c, r); n++; end
      lens[c] = n; expReads += n;
      if (n > 0) begin expVec[expCnt] = v; expLen[expCnt] = n; expRow[expCnt] = 0; expCnt++; end
    end
    for (int r = 0; r < 8; r++) begin
      v = '0; n = 0;
      for (int c = 0; c < 8; c++)
        if (lens[c] > r) begin v[n*DW +: DW] = memVal(blkNo, r*8+c); n++; end
      if (n > 0) begin expVec[expCnt] = v; expLen[expCnt] = n; expRow[expCnt] = 1; expCnt++; end
    end
  endtask

  task automatic sendColumn(input int c);
    for (int r = 0; r < 8; r++) begin
      if (gapMode && ($urandom % 4) == 0) begin pixValid = 0; @(negedge clk); end
      pixValid = 1; pixData = pixVal(blkNo, c, r); pixAlpha = alpha[c*8+r];
      while (!pixReady) @(negedge clk);
      @(negedge clk);
    end
    pixValid = 0;
  endtask

  task automatic waitDone(input string tag);
    int t = 0;
    while (expIdx < expCnt && t < 3000) begin @(negedge clk); t++; end
    repeat (24) @(negedge clk);
    check(expIdx == expCnt, $sformatf("R4 %s vectors taken %0d exp %0d", tag, expIdx, expCnt));
    check(readCnt == expReads, $sformatf("R7 %s reads %0d exp %0d", tag, readCnt, expReads));
    check(badRead == 0, $sformatf("R7 %s illegal reads %0d exp 0", tag, badRead));
    check(violR10 == 0, $sformatf("R10 %s pixReady during row pass %0d exp 0", tag, violR10));
  endtask

  task automatic runBlock(input logic [63:0] am, input string tag);
    setupBlock(am);
    for (int c = 0; c < 8; c++) sendColumn(c);
    waitDone(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL R4 watchdog: cycles=%0d expected below 150000", cyc);
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin
    logic [63:0] am;
    int t0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!vecValid && !tmRdEn, $sformatf("R11 reset: valid=%0b rd=%0b exp 0 0", vecValid, tmRdEn));
    rstN = 1;
    @(negedge clk);
    check(pixReady, $sformatf("R11 pixReady=%0b exp 1", pixReady));

    // R9 full block
    runBlock({64{1'b1}}, "R9 full");
    check(expCnt == 16, $sformatf("R9 vector count %0d exp 16", expCnt));
    // R8 empty block
    runBlock('0, "R8 empty");
    check(pixReady, $sformatf("R8 next block accepted: pixReady=%0b exp 1", pixReady));
    // R3 empty inner column, lone last-row pixel
    am = 64'h5A3C_80FF_0011_7E81; am[3*8 +: 8] = 8'h00; am[5*8 +: 8] = 8'h80;
    runBlock(am, "R3 sparse");

    // R5 double buffering with output held
    gapMode = 0;
    am = {48'hF0F0_1234_8001, 16'hFFFF};
    setupBlock(am);
    readyMode = 1;
    sendColumn(0);
    t0 = cyc;
    sendColumn(1);
    check(cyc - t0 <= 10, $sformatf("R5 next column took %0d cycles exp <=10", cyc - t0));
    check(vecValid && expIdx == 0 && vecData[DW-1:0] == pixVal(blkNo, 0, 0),
          $sformatf("R5 held vector: valid=%0b lane0=%h exp 1 %h", vecValid, vecData[DW-1:0],
                    pixVal(blkNo, 0, 0)));
    readyMode = 0;
    for (int c = 2; c < 8; c++) sendColumn(c);
    waitDone("R5 held");

    // random blocks, R1 R6
    gapMode = 1;
    for (int b = 0; b < 30; b++) begin
      for (int c = 0; c < 8; c++)
        case ($urandom % 4)
          0: am[c*8 +: 8] = 8'h00;
          1: am[c*8 +: 8] = 8'hFF;
          default: am[c*8 +: 8] = 8'($urandom);
        endcase
      readyMode = (b % 5 == 4) ? 2 : 0;
      runBlock(am, "random");
    end

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule